// File: doc/BRIEF.md
# Chip-Select Watchdog Timer

This block watches a line that a processor uses both as a chip select and as a keep-alive signal. The processor proves it is alive by driving a high-to-low transition on that line. If no such transition arrives within the selected interval, the block raises a reset request. That request is merged into the supervisor's system reset. A steady level, whether high or low, never counts as activity.

A 2-bit select input picks the interval from three preset tick counts, or disables the watchdog. The select comes from stored configuration and is expected to stay stable. Intervals are counted on a one-cycle tick from an external timebase, not on raw clocks.

After a timeout, the reset request is held for a fixed number of ticks. The interval count then starts again from zero.

Top module: `cs_watchdog`

## Requirements
- R1: A high-to-low transition on `cs_i` that is held for at least three clocks restarts the interval count from zero.
- R2: With no falling edge on `cs_i`, `wd_rst_o` rises on the clock after the tick that completes the selected interval. This is the same whether `cs_i` stays high or stays low.
- R3: `cs_i` passes through a two-flop synchronizer before edge detection. A rising edge on `cs_i` does not restart the count.
- R4: `sel_i` encodings: 2'b00 gives 4 ticks, 2'b01 gives 8 ticks, 2'b10 gives 16 ticks, and 2'b11 disables the watchdog. While disabled, `wd_rst_o` never asserts.
- R5: Once asserted, `wd_rst_o` stays high for exactly 3 ticks. The next timeout then needs a full interval counted from zero.
- R6: Falling edges on `cs_i` while `wd_rst_o` is high have no effect on how long it stays high.
- R7: A change of `sel_i` restarts the count, so the new interval is measured from the change.
- R8: An active `rst_ni` forces `wd_rst_o` low and clears the count, including during a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Asynchronous chip-select / keep-alive line |
| sel_i | input | 2 | Interval select (2'b11 = disabled) |
| tick_i | input | 1 | One-cycle timebase pulse |
| wd_rst_o | output | 1 | Reset request, active high |

## Verification
The bench holds `cs_i` low after a kick and checks that a timeout still follows. A design that restarted on level would never time out. It raises `cs_i` just before the deadline; a design that counted rising edges would miss the expiry. It changes the select mid-count to a longer interval, where a design without a restart would fire early. It also kicks during a reset request; a design that honoured that kick would shorten the request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // idle level of a chip select is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cs_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  // R3
  single_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int unsigned T_SHORT = 4,
  parameter int unsigned T_MID   = 8,
  parameter int unsigned T_LONG  = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] limit_o,
  output logic             en_o,
  output logic             restart_o
);
  logic [1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= WD_OFF;
    else         sel_q <= sel_i;
  end

  always_comb begin
    unique case (wd_sel_e'(sel_i))
      WD_SHORT: limit_o = CNT_W'(T_SHORT);
      WD_MID:   limit_o = CNT_W'(T_MID);
      WD_LONG:  limit_o = CNT_W'(T_LONG);
      default:  limit_o = '1;
    endcase
  end

  assign en_o      = (sel_i != WD_OFF);
  assign restart_o = (sel_i != sel_q);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 3,
  parameter int unsigned CNT_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

  wd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (state_q == ST_HOLD) begin
      // fixed-length request, kicks ignored
      if (tick_i) begin
        if (cnt_q == HOLD_LAST) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (kick_i || restart_i || !en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == limit_i - 1'b1) begin
        state_q <= ST_HOLD;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_req_o = (state_q == ST_HOLD);

  // R1
  kick_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && !rst_req_o) |=> (cnt_q == '0 && !rst_req_o));
  // R4
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !rst_req_o) |=> !rst_req_o);
  // R2
  rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(tick_i));
  // R5
  fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> $past(tick_i));
  // R6
  hold_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !tick_i) |=> rst_req_o);
endmodule

// File: rtl/cs_watchdog.sv
module cs_watchdog #(
  parameter int unsigned T_SHORT     = 4,
  parameter int unsigned T_MID       = 8,
  parameter int unsigned T_LONG      = 16,
  parameter int unsigned HOLD_TICKS  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       wd_rst_o
);
  localparam int unsigned MAX_T = (T_LONG > HOLD_TICKS) ? T_LONG : HOLD_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic             kick;
  logic             restart;
  logic             en;
  logic [CNT_W-1:0] limit;

  wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_i),
    .fall_o (kick)
  );

  wdt_period_sel #(
    .T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG), .CNT_W(CNT_W)
  ) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .limit_o   (limit),
    .en_o      (en),
    .restart_o (restart)
  );

  wdt_core #(.HOLD_TICKS(HOLD_TICKS), .CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .kick_i    (kick),
    .restart_i (restart),
    .en_i      (en),
    .limit_i   (limit),
    .rst_req_o (wd_rst_o)
  );
endmodule

// File: tb/cs_watchdog_test.sv
`timescale 1ns/1ps
module cs_watchdog_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       tick = 1'b0;
  logic       wd_rst;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cs_watchdog uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs),
    .sel_i(sel), .tick_i(tick), .wd_rst_o(wd_rst)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wd_rst_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ends with cs low and count cleared
  task automatic kick_low();
    cs = 1'b1; wait_clk(3);
    cs = 1'b0; wait_clk(3);
  endtask

  task automatic kick_high();
    kick_low();
    cs = 1'b1; wait_clk(3);
  endtask

  task automatic clear();
    while (wd_rst) do_tick(1);
  endtask

  task automatic set_sel(input logic [1:0] s);
    sel = s; wait_clk(2);
  endtask

  task automatic t_reset();
    wait_clk(1);
    check("R8 reset state", wd_rst, 1'b0);
  endtask

  task automatic t_high_timeout();
    set_sel(2'b00); kick_high();
    do_tick(3); check("R2 high before deadline", wd_rst, 1'b0);
    do_tick(1); check("R2 high at deadline", wd_rst, 1'b1);
  endtask

  task automatic t_hold();
    do_tick(2); check("R5 hold still active", wd_rst, 1'b1);
    do_tick(1); check("R5 hold released", wd_rst, 1'b0);
    do_tick(3); check("R5 restart from zero early", wd_rst, 1'b0);
    do_tick(1); check("R5 restart from zero full", wd_rst, 1'b1);
    clear();
  endtask

  task automatic t_kick();
    kick_high(); do_tick(3);
    kick_high(); do_tick(3);
    check("R1 kick restarted count", wd_rst, 1'b0);
    do_tick(1); check("R1 timeout after kick", wd_rst, 1'b1);
    clear();
  endtask

  task automatic t_low_timeout();
    kick_low();
    do_tick(3); check("R2 low before deadline", wd_rst, 1'b0);
    do_tick(1); check("R2 low at deadline", wd_rst, 1'b1);
    clear();
  endtask

  task automatic t_rise_ignored();
    kick_low(); do_tick(3);
    cs = 1'b1; wait_clk(3);
    do_tick(1); check("R3 rising edge no kick", wd_rst, 1'b1);
    clear();
  endtask

  task automatic t_intervals();
    set_sel(2'b01); kick_high();
    do_tick(7); check("R4 sel01 before 8", wd_rst, 1'b0);
    do_tick(1); check("R4 sel01 at 8", wd_rst, 1'b1);
    clear();
    set_sel(2'b10); kick_high();
    do_tick(15); check("R4 sel10 before 16", wd_rst, 1'b0);
    do_tick(1); check("R4 sel10 at 16", wd_rst, 1'b1);
    clear();
    set_sel(2'b11); kick_high();
    do_tick(40); check("R4 sel11 disabled", wd_rst, 1'b0);
  endtask

  task automatic t_sel_change();
    set_sel(2'b00); kick_high(); do_tick(2);
    set_sel(2'b01);
    do_tick(5); check("R7 no early fire", wd_rst, 1'b0);
    do_tick(2); check("R7 before new deadline", wd_rst, 1'b0);
    do_tick(1); check("R7 at new deadline", wd_rst, 1'b1);
    clear();
  endtask

  task automatic t_kick_in_hold();
    set_sel(2'b00); kick_high(); do_tick(4);
    check("R6 request raised", wd_rst, 1'b1);
    kick_high();
    do_tick(2); check("R6 kick ignored in hold", wd_rst, 1'b1);
    do_tick(1); check("R6 hold length kept", wd_rst, 1'b0);
    do_tick(3); check("R6 count after hold", wd_rst, 1'b0);
    do_tick(1); check("R6 timeout after hold", wd_rst, 1'b1);
  endtask

  task automatic t_reset_mid();
    rst_ni = 1'b0; wait_clk(1);
    check("R8 reset clears request", wd_rst, 1'b0);
    rst_ni = 1'b1;
    kick_high(); do_tick(3);
    rst_ni = 1'b0; wait_clk(1); rst_ni = 1'b1; wait_clk(3);
    do_tick(3); check("R8 count cleared", wd_rst, 1'b0);
    do_tick(1); check("R8 full interval after reset", wd_rst, 1'b1);
  endtask

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    t_reset();
    t_high_timeout();
    t_hold();
    t_kick();
    t_low_timeout();
    t_rise_ignored();
    t_intervals();
    t_sel_change();
    t_kick_in_hold();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule